// File: doc/BRIEF.md
# SD command and response engine

This block issues a single SD command on the CMD line and collects the reply. The caller supplies a 6-bit command index, a 32-bit argument, a response type and a flag marking commands that will move data. The engine builds a 48-bit frame with a CRC7 and shifts it out. It then waits a bounded time for the card's start bit. It receives a 48-bit or 136-bit reply and checks it according to the response type. The outcome is recorded in a sticky status word that software clears bit by bit.

A one-cycle `tick` strobe paces the line. Each tick is one SD clock period. Every line transition and every line sample happens in a cycle where `tick` is high. The clock divider and the data-block path live outside this block. The data path tells the engine, through `data_active_i`, when the data lines are in use.

A second command may be requested while one is in flight. It is held and launched as soon as the line is free. Busy-type commands stay open until the card releases DAT0.

Top module: `sd_cmd_engine`

## Requirements
- R1: A launched command is sent MSB first, one bit per tick, as 48 bits in this order: 0, 1, index[5:0], argument[31:0], CRC7 over those first 40 bits (polynomial x^7+x^3+1, register starting at zero), then 1. `cmd_oe` is high exactly while the frame is driven, and `cmd_o` idles at 1.
- R2: A request made while a command is in progress is held, with `cmd_busy` high. It is sent after the current command finishes. A further request arriving while one is already held is dropped.
- R3: A held command of type R1b, or one with `uses_data` set, is not launched while `data_active_i` is high.
- R4: The `rsp_type` encoding is 0 none, 1 R1, 2 R1b, 3 R2, 4 R3; values 5 to 7 act as none. Type none completes when the frame's stop bit has been sent. Type R2 expects 136 response bits. Every other type expects 48.
- R5: After the stop bit the engine samples CMD on up to 64 ticks. If no 0 is seen, status bit 1 (timeout) is set and bit 0 is not.
- R6: The received CRC7 is compared only for R1, R1b and R2. For 48-bit replies it covers the first 40 bits. For R2 it covers the 120 bits after the 8-bit header. A mismatch sets status bit 2.
- R7: The echoed 6-bit index, in reply bits 45:40, is compared with the sent index only for R1 and R1b. A mismatch sets status bit 4.
- R8: A reply whose final bit is 0 sets status bit 3.
- R9: After a 48-bit reply, `resp[31:0]` holds reply bits 39:8 and `resp[127:32]` is zero. After an R2 reply, `resp[119:0]` holds reply bits 127:8 and `resp[127:120]` is zero.
- R10: For R1b, status bit 0 is set only on a tick where DAT0 is sampled high after the reply has ended.
- R11: Status bit 0 (complete) is set when a reply has been processed, or when a type-none frame has ended. Bits 4:0 stay set until cleared by a `clr_wr` pulse with the matching `clr_mask` bit at 1. Bit 15 is the OR of bits 4:1.
- R12: After reset, `status` is 0, `cmd_oe` is 0, `cmd_o` is 1 and `cmd_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per SD clock period |
| issue | input | 1 | Request to send the command on the fields below |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_type | input | 3 | Expected response type |
| uses_data | input | 1 | Command will use the data lines |
| data_active_i | input | 1 | Data lines currently in use |
| cmd_i | input | 1 | CMD line as seen by the host |
| dat0_i | input | 1 | DAT0 line, low while the card is busy |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 5 | Status bits 4:0 to clear, 1 clears |
| cmd_o | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_busy | output | 1 | A command is held or in progress |
| status | output | 16 | Sticky status word |
| resp | output | 128 | Stored response |

## Verification
With `tick` high on every cycle, an `issue` pulse is taken by the first clock edge and the frame starts on the second. The bench therefore does not predict the first frame bit. It follows `cmd_oe` on each falling clock edge and collects exactly 48 bits.

Response bits are driven on falling edges, one per cycle, starting the cycle after the stop bit. The start bit is sampled on the wait tick numbered delay plus one. The status word is read two falling edges after the final reply bit, to cover the receive edge and the check edge. A timeout is read one falling edge after the 64th idle tick. An R1b completion is read one falling edge after DAT0 rises. A clear is read one falling edge after the `clr_wr` pulse.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int RSP_WAIT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         issue,
  input  logic [5:0]   cmd_idx,
  input  logic [31:0]  cmd_arg,
  input  logic [2:0]   rsp_type,
  input  logic         uses_data,
  input  logic         data_active_i,
  input  logic         cmd_i,
  input  logic         dat0_i,
  input  logic         clr_wr,
  input  logic [4:0]   clr_mask,
  output logic         cmd_o,
  output logic         cmd_oe,
  output logic         cmd_busy,
  output logic [15:0]  status,
  output logic [127:0] resp
);

  localparam int TW = $clog2(RSP_WAIT + 1);
  localparam logic [2:0] T_R1 = 3'd1, T_R1B = 3'd2, T_R2 = 3'd3, T_R3 = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_CHK, S_BUSY} st_t;

  function automatic logic [6:0] crc7(input logic [119:0] d, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 119; i >= 0; i--)
      if (i < n) begin
        fb = d[i] ^ c[6];
        c  = {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
      end
    return c;
  endfunction

  st_t          st;
  logic         p_vld, p_dat;
  logic [5:0]   p_idx, a_idx;
  logic [31:0]  p_arg;
  logic [2:0]   p_type, a_type;
  logic [47:0]  tx_sr;
  logic [7:0]   cnt;
  logic [TW-1:0] tmr;
  logic [127:0] rx_sr;
  logic [4:0]   sts;

  logic [39:0] hdr;
  logic        need_rsp, go, chk_crc, chk_idx;
  logic [7:0]  a_last;
  logic [6:0]  crc_calc;
  logic        crc_bad, idx_bad, end_bad, set_cmp, set_to, in_chk;
  logic [4:0]  set_v, clr_v;

  assign hdr      = {2'b01, p_idx, p_arg};
  assign go       = p_vld && st == S_IDLE && !((p_dat || p_type == T_R1B) && data_active_i);
  assign need_rsp = a_type inside {T_R1, T_R1B, T_R2, T_R3};
  assign chk_crc  = a_type inside {T_R1, T_R1B, T_R2};
  assign chk_idx  = a_type inside {T_R1, T_R1B};
  assign a_last   = (a_type == T_R2) ? 8'd135 : 8'd47;
  assign crc_calc = (a_type == T_R2) ? crc7(rx_sr[127:8], 120) : crc7({80'b0, rx_sr[47:8]}, 40);

  assign in_chk  = st == S_CHK;
  assign crc_bad = in_chk && chk_crc && crc_calc != rx_sr[7:1];
  assign idx_bad = in_chk && chk_idx && rx_sr[45:40] != a_idx;
  assign end_bad = in_chk && !rx_sr[0];
  assign set_cmp = (st == S_TX && tick && cnt == 8'd47 && !need_rsp)
                || (in_chk && a_type != T_R1B)
                || (st == S_BUSY && tick && dat0_i);
  assign set_to  = st == S_WAIT && tick && cmd_i && tmr == TW'(RSP_WAIT - 1);
  assign set_v   = {idx_bad, end_bad, crc_bad, set_to, set_cmp};
  assign clr_v   = clr_wr ? clr_mask : 5'b0;

  assign cmd_oe   = st == S_TX;
  assign cmd_o    = (st == S_TX) ? tx_sr[47] : 1'b1;
  assign cmd_busy = p_vld || st != S_IDLE;
  assign status   = {|sts[4:1], 10'b0, sts};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_dat  <= 1'b0;
      p_idx  <= '0;
      p_arg  <= '0;
      p_type <= '0;
    end else if (go) begin
      p_vld <= 1'b0;
    end else if (issue && !p_vld) begin
      p_vld  <= 1'b1;
      p_dat  <= uses_data;
      p_idx  <= cmd_idx;
      p_arg  <= cmd_arg;
      p_type <= rsp_type;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      a_idx  <= '0;
      a_type <= '0;
      tx_sr  <= '0;
      cnt    <= '0;
      tmr    <= '0;
      rx_sr  <= '0;
      resp   <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          tx_sr  <= {hdr, crc7({80'b0, hdr}, 40), 1'b1};
          a_idx  <= p_idx;
          a_type <= p_type;
          cnt    <= '0;
          st     <= S_TX;
        end
        S_TX: if (tick) begin
          tx_sr <= {tx_sr[46:0], 1'b0};
          if (cnt == 8'd47) begin
            tmr <= '0;
            st  <= need_rsp ? S_WAIT : S_IDLE;
          end else cnt <= cnt + 8'd1;
        end
        S_WAIT: if (tick) begin
          if (!cmd_i) begin
            rx_sr <= {rx_sr[126:0], 1'b0};
            cnt   <= 8'd1;
            st    <= S_RX;
          end else if (tmr == TW'(RSP_WAIT - 1)) st <= S_IDLE;
          else tmr <= tmr + 1'b1;
        end
        S_RX: if (tick) begin
          rx_sr <= {rx_sr[126:0], cmd_i};
          if (cnt == a_last) st <= S_CHK;
          else cnt <= cnt + 8'd1;
        end
        S_CHK: begin
          resp <= (a_type == T_R2) ? {8'b0, rx_sr[127:8]} : {96'b0, rx_sr[39:8]};
          st   <= (a_type == T_R1B) ? S_BUSY : S_IDLE;
        end
        S_BUSY: if (tick && dat0_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_o);

  // R3
  data_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !($past(data_active_i) && ($past(p_dat) || $past(p_type) == T_R1B)));

  // R5
  to_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> !$rose(status[0]));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BUSY && !dat0_i) |=> !$rose(status[0]));

endmodule

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb;

  logic clk = 0, rst_n = 0, tick = 1, issue = 0, uses_data = 0, data_active_i = 0;
  logic cmd_i = 1, dat0_i = 1, clr_wr = 0;
  logic [5:0] cmd_idx = 0;
  logic [31:0] cmd_arg = 0;
  logic [2:0] rsp_type = 0;
  logic [4:0] clr_mask = 0;
  logic cmd_o, cmd_oe, cmd_busy;
  logic [15:0] status;
  logic [127:0] resp;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sd_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .issue(issue), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .rsp_type(rsp_type), .uses_data(uses_data),
    .data_active_i(data_active_i), .cmd_i(cmd_i), .dat0_i(dat0_i),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
    .cmd_busy(cmd_busy), .status(status), .resp(resp)
  );

  task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [135:0] v, input int hi, input int n);
    logic [6:0] c = 0;
    logic t;
    for (int k = 0; k < n; k++) begin
      t = c[6] ^ v[hi-k];
      c = c << 1;
      if (t) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] mkframe(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h = {2'b01, idx, arg};
    return {h, bcrc({96'b0, h}, 39, 40), 1'b1};
  endfunction

  function automatic logic [15:0] exp_sts(input logic [2:0] typ, input int mode, input int dly);
    logic [4:0] e = 5'b00001;
    if (typ == 0 || typ > 4) return 16'h0001;
    if (dly >= 64) return 16'h8002;
    if (mode == 1 && typ inside {3'd1, 3'd2, 3'd3}) e[2] = 1;
    if (mode == 2 && typ inside {3'd1, 3'd2}) e[4] = 1;
    if (mode == 3) e[3] = 1;
    return {|e[4:1], 10'b0, e};
  endfunction

  task automatic clear(input logic [4:0] m);
    @(negedge clk); clr_wr = 1; clr_mask = m;
    @(negedge clk); clr_wr = 0; clr_mask = 0;
  endtask

  task automatic cap_frame(output logic [47:0] f);
    int got = 0;
    f = 0;
    while (got < 48) begin
      @(negedge clk);
      if (cmd_oe) begin f = {f[46:0], cmd_o}; got++; end
    end
  endtask

  // mode: 0 clean, 1 bad crc field, 2 bad index field, 3 end bit 0
  task automatic do_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [2:0] typ,
                        input bit dat, input int hold, input int dly, input int mode,
                        input int blen, input logic [119:0] body, input logic [31:0] rarg);
    logic [47:0] f;
    logic [135:0] rv;
    logic [39:0] h;
    logic [7:0] h8;
    logic [6:0] c;
    logic [15:0] es, es2;
    int rlen;
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; rsp_type = typ; uses_data = dat; issue = 1;
    if (hold > 0) data_active_i = 1;
    @(negedge clk); issue = 0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R3 held while data lines busy", cmd_oe, 0);
    end
    data_active_i = 0;
    cap_frame(f);
    check("R1 frame", f, mkframe(idx, arg));
    es = exp_sts(typ, mode, dly);
    if (typ == 0 || typ > 4) begin
      @(negedge clk);
      check("R4 none completes", status, es);
    end else if (dly >= 64) begin
      for (int k = 0; k < 64; k++) begin @(negedge clk); cmd_i = 1; end
      @(negedge clk);
      check("R5 timeout", status, es);
    end else begin
      if (typ == 3) begin
        h8 = (mode == 2) ? 8'h3E : 8'h3F;
        c = bcrc({16'b0, body}, 119, 120) ^ ((mode == 1) ? 7'h01 : 7'h00);
        rv = {h8, body, c, (mode == 3) ? 1'b0 : 1'b1};
        rlen = 136;
      end else begin
        h = {2'b00, ((typ == 4) ? 6'h3F : idx) ^ ((mode == 2) ? 6'h01 : 6'h00), rarg};
        c = ((typ == 4) ? 7'h7F : bcrc({96'b0, h}, 39, 40)) ^ ((mode == 1) ? 7'h01 : 7'h00);
        rv = {88'b0, h, c, (mode == 3) ? 1'b0 : 1'b1};
        rlen = 48;
      end
      for (int k = 0; k < dly; k++) begin @(negedge clk); cmd_i = 1; end
      for (int k = rlen - 1; k >= 0; k--) begin
        @(negedge clk); cmd_i = rv[k];
        if (k == 0 && typ == 2) dat0_i = 0;
      end
      @(negedge clk); cmd_i = 1;
      @(negedge clk);
      if (typ == 2) begin
        check("R10 busy holds complete", status[0], 0);
        for (int k = 0; k < blen; k++) begin
          @(negedge clk);
          check("R10 still busy", status[0], 0);
        end
        dat0_i = 1;
        @(negedge clk);
      end
      check("R6 R7 R8 R11 status", status, es);
      check("R9 response", resp, (typ == 3) ? {16'b0, body} : {104'b0, rarg});
    end
    clear(5'b00100);
    es2 = {es[15:3], 1'b0, es[1:0]};
    es2[15] = |es2[4:1];
    check("R11 partial clear", status, es2);
    clear(5'b11111);
    check("R11 full clear", status, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0] two;
    logic [47:0] fa, fb2;
    void'($urandom(32'h5D17));
    repeat (3) @(negedge clk);
    check("R12 status", status, 0);
    check("R12 oe", cmd_oe, 0);
    check("R12 cmd_o", cmd_o, 1);
    check("R12 busy", cmd_busy, 0);
    rst_n = 1;

    check("R1 crc of index 0 arg 0", bcrc({96'b0, 40'h40_0000_0000}, 39, 40), 7'h4A);
    check("R1 crc of index 8 arg 1AA", bcrc({96'b0, 40'h48_0000_01AA}, 39, 40), 7'h43);
    do_cmd(6'd0, 32'h0, 3'd0, 0, 0, 0, 0, 0, '0, '0);
    do_cmd(6'd8, 32'h1AA, 3'd1, 0, 0, 0, 0, 0, '0, 32'h0000_01AA);
    do_cmd(6'd8, 32'h1AA, 3'd1, 0, 0, 63, 0, 0, '0, 32'h1234_5678);
    do_cmd(6'd55, 32'h0, 3'd1, 0, 0, 64, 0, 0, '0, '0);
    do_cmd(6'd41, 32'h4000_0000, 3'd4, 0, 0, 3, 1, 0, '0, 32'hC0FF_8000);
    do_cmd(6'd41, 32'h4000_0000, 3'd4, 0, 0, 3, 2, 0, '0, 32'h80FF_8000);
    do_cmd(6'd2, 32'h0, 3'd3, 0, 0, 5, 0, 0, 120'hA5_1234_5678_9ABC_DEF0_1122_3344_5566, '0);
    do_cmd(6'd9, 32'h1234_0000, 3'd3, 0, 0, 5, 1, 0, 120'h0F_EDCB_A987_6543_2100_FFEE_DDCC_BBAA, '0);
    do_cmd(6'd9, 32'h1234_0000, 3'd3, 0, 0, 2, 2, 0, 120'h33, '0);
    do_cmd(6'd13, 32'h5678_0000, 3'd1, 0, 0, 1, 1, 0, '0, 32'h900);
    do_cmd(6'd13, 32'h5678_0000, 3'd1, 0, 0, 1, 2, 0, '0, 32'h900);
    do_cmd(6'd16, 32'h200, 3'd1, 0, 0, 1, 3, 0, '0, 32'h900);
    do_cmd(6'd7, 32'h1234_0000, 3'd2, 0, 0, 2, 0, 6, '0, 32'h700);
    do_cmd(6'd17, 32'h10, 3'd1, 1, 7, 2, 0, 0, '0, 32'h900);
    do_cmd(6'd12, 32'h0, 3'd2, 0, 5, 2, 0, 3, '0, 32'hB00);
    do_cmd(6'd5, 32'hDEAD, 3'd6, 0, 0, 0, 0, 0, '0, '0);

    // R2 queued request
    fork
      begin
        int got = 0;
        two = 0;
        while (got < 96) begin
          @(negedge clk);
          if (cmd_oe) begin two = {two[94:0], cmd_o}; got++; end
        end
      end
      begin
        @(negedge clk); cmd_idx = 6'd0; cmd_arg = 32'h0; rsp_type = 0; uses_data = 0; issue = 1;
        @(negedge clk); issue = 0;
        @(negedge clk); cmd_idx = 6'd63; cmd_arg = 32'hFFFF_0001; issue = 1;
        @(negedge clk); issue = 0;
        check("R2 busy while queued", cmd_busy, 1);
        @(negedge clk); cmd_idx = 6'd21; cmd_arg = 32'h77; issue = 1;
        @(negedge clk); issue = 0;
      end
    join
    fa = mkframe(6'd0, 32'h0);
    fb2 = mkframe(6'd63, 32'hFFFF_0001);
    check("R2 two frames in order", two, {fa, fb2});
    repeat (4) @(negedge clk);
    check("R2 extra request dropped", cmd_busy, 0);
    check("R2 extra request sent nothing", cmd_oe, 0);
    clear(5'b11111);

    for (int n = 0; n < 40; n++) begin
      logic [2:0] t;
      int md, dl;
      t = 3'($urandom % 5);
      md = $urandom % 5;
      dl = (n % 9 == 8) ? 64 : $urandom % 20;
      do_cmd(6'($urandom), $urandom, t, 1'($urandom), 0, dl, (md == 4) ? 0 : md,
             1 + $urandom % 5, {$urandom, $urandom, $urandom, $urandom}, $urandom);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule